// File: doc/BRIEF.md
# EEPROM Erase/Write Cycle Sequencer

This block models the internal programming phase of a small serial EEPROM. The cycle runs after the bus front end has accepted a complete write transfer and seen the STOP that ends it. Before that, the front end loads the received data bytes into a staging buffer. It then raises a one-cycle commit strobe with the first word address, the number of staged bytes and a flag that selects byte mode or page mode. The sequencer then moves the staged bytes into the cell array. For the whole cycle it holds a registered busy flag, and it pulses done for one cycle when busy drops.

The length of the cycle is counted in timing units. A unit is either a fixed number of system clocks (internal oscillator) or a run-time count of external millisecond ticks, clamped to a legal window. A byte-mode transfer costs one unit for each byte, and each byte lands in the array as its unit ends. Address order is linear and wraps at the top of the array. A page-mode transfer always costs nine units no matter how many bytes were sent. Its bytes stay inside one aligned page with a wrapping low address, and all of them land together when the last unit ends. While busy, the block refuses new commits, refuses staging writes and forces the address acknowledge to the front end low. The bus itself stays free for other traffic.

Top module: `ee_wcyc_seq`

## Requirements
- R1: After reset busy_o and done_o are low and every array word reads 8'hFF (erased).
- R2: A commit_i while idle with commit_cnt_i from 1 to PAGE_BYTES (8) sets busy_o in the next cycle.
- R3: In byte mode (commit_page_i = 0) with the internal timebase, busy_o stays high for exactly commit_cnt_i × UNIT_CLKS clock cycles.
- R4: In page mode (commit_page_i = 1), busy_o lasts exactly PAGE_UNITS (9) units, whatever the byte count.
- R5: In byte mode, staging slot k is written to address (commit_addr_i + k) mod 2^ADDR_W, so the sequence wraps from 8'hFF to 8'h00.
- R6: In page mode, staging slot k is written to the address whose upper ADDR_W-3 bits equal those of commit_addr_i and whose low 3 bits are (commit_addr_i[2:0] + k) mod 8. Other words of the page are left as they were.
- R7: In byte mode, byte k becomes readable on rd_data_o in the cycle after unit k+1 ends, so the first byte appears after UNIT_CLKS cycles while busy_o is still high. In page mode no byte changes before the last unit ends.
- R8: A commit_i while busy, or with commit_cnt_i of 0 or greater than PAGE_BYTES, starts nothing and writes nothing.
- R9: While busy_o is high, ack_o is low even when addr_hit_i is high, and staging writes are dropped. When idle, ack_o follows addr_hit_i.
- R10: With tb_ext_i = 1 at commit, one unit is ext_len_i pulses of ext_tick_i, with ext_len_i clamped to the range 4 to 10. The selection and the length are sampled at commit.
- R11: done_o is high for exactly the one cycle following the clock edge at which busy_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_we_i | input | 1 | Write one staging slot |
| stage_slot_i | input | 3 | Staging slot index |
| stage_data_i | input | 8 | Staging slot data |
| commit_i | input | 1 | One-cycle strobe: start a programming cycle |
| commit_addr_i | input | 8 | Word address of the first byte |
| commit_cnt_i | input | 4 | Number of staged bytes |
| commit_page_i | input | 1 | 1 = page mode, 0 = byte mode |
| tb_ext_i | input | 1 | 1 = use external tick timebase |
| ext_len_i | input | 4 | External ticks per unit (clamped 4..10) |
| ext_tick_i | input | 1 | External timebase tick, one clock wide |
| addr_hit_i | input | 1 | Front end has matched the device address |
| ack_o | output | 1 | Address acknowledge permitted |
| busy_o | output | 1 | Programming cycle in progress |
| done_o | output | 1 | One-cycle pulse at end of cycle |
| rd_addr_i | input | 8 | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
The assertions watch things on every cycle. The acknowledge is held off while busy. A legal idle commit always raises busy, and an illegal one never does. Done always coincides with the fall of busy. A counter in the checker compares the busy length on the internal timebase with the count or nine units. The placement of bytes cannot be seen by a property over the ports: linear wrap, page wrap, the moment each byte lands, and the data kept in staging slots after a dropped write. The external tick counting and its clamp are in the same position. The directed scenarios show these by reading the array back and counting ticks.

// File: rtl/ee_wcyc_pkg.sv
package ee_wcyc_pkg;

   typedef enum logic [0:0] {
      CYC_IDLE = 1'b0,
      CYC_RUN  = 1'b1
   } cyc_state_e;

   typedef enum logic [0:0] {
      WMODE_BYTE = 1'b0,
      WMODE_PAGE = 1'b1
   } wmode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ee_wcyc_timebase.sv
module ee_wcyc_timebase #(
   parameter  int unsigned UNIT_CLKS = 7000,
   parameter  bit          EXT_TB_EN = 1'b1,
   parameter  int unsigned EXT_MIN   = 4,
   parameter  int unsigned EXT_MAX   = 10,
   localparam int unsigned TW        = $clog2(UNIT_CLKS),
   localparam int unsigned LW        = $clog2(EXT_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic          run_i,
   input  logic          use_ext_i,
   input  logic [LW-1:0] ext_len_i,
   input  logic          ext_tick_i,
   output logic          unit_end_o
);

   logic [TW-1:0] tcnt_q;
   logic          int_end;

   assign int_end = (tcnt_q == TW'(UNIT_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
      end else if (restart_i) begin
         tcnt_q <= '0;
      end else if (run_i) begin
         tcnt_q <= int_end ? '0 : tcnt_q + 1'b1;
      end
   end

   generate
      if (EXT_TB_EN) begin : g_ext
         logic          sel_q;
         logic [LW-1:0] len_q;
         logic [LW-1:0] ecnt_q;
         logic [LW-1:0] len_clamped;
         logic          ext_end;

         always_comb begin
            if (ext_len_i < LW'(EXT_MIN))      len_clamped = LW'(EXT_MIN);
            else if (ext_len_i > LW'(EXT_MAX)) len_clamped = LW'(EXT_MAX);
            else                               len_clamped = ext_len_i;
         end

         assign ext_end = ext_tick_i && (ecnt_q == len_q - 1'b1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q  <= 1'b0;
               len_q  <= LW'(EXT_MIN);
               ecnt_q <= '0;
            end else if (restart_i) begin
               sel_q  <= use_ext_i;
               len_q  <= len_clamped;
               ecnt_q <= '0;
            end else if (run_i && ext_tick_i) begin
               ecnt_q <= ext_end ? '0 : ecnt_q + 1'b1;
            end
         end

         assign unit_end_o = run_i && (sel_q ? ext_end : int_end);
      end else begin : g_int_only
         logic unused_ext;
         assign unused_ext = ^{use_ext_i, ext_len_i, ext_tick_i};
         assign unit_end_o = run_i && int_end;
      end
   endgenerate

endmodule

// File: rtl/ee_wcyc_ctrl.sv
module ee_wcyc_ctrl
   import ee_wcyc_pkg::*;
#(
   parameter  int unsigned ADDR_W     = 8,
   parameter  int unsigned PAGE_BYTES = 8,
   parameter  int unsigned PAGE_UNITS = 9,
   localparam int unsigned CW         = $clog2(PAGE_BYTES + 1),
   localparam int unsigned PG_W       = $clog2(PAGE_BYTES),
   localparam int unsigned UW         = $clog2(max_u(PAGE_UNITS, PAGE_BYTES) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] commit_addr_i,
   input  logic [CW-1:0]     commit_cnt_i,
   input  logic              commit_page_i,
   input  logic              unit_end_i,
   output logic              accept_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              byte_we_o,
   output logic [ADDR_W-1:0] byte_addr_o,
   output logic [PG_W-1:0]   byte_slot_o,
   output logic              flush_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [CW-1:0]     cnt_o
);

   cyc_state_e        state_q;
   wmode_e            mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] base_q;
   logic [CW-1:0]     cnt_q;
   logic [UW-1:0]     units_q;
   logic [PG_W-1:0]   slot_q;
   logic              done_q;
   logic              running;
   logic              last_unit;
   logic              cnt_legal;

   assign running   = (state_q == CYC_RUN);
   assign cnt_legal = (commit_cnt_i != '0) && (commit_cnt_i <= CW'(PAGE_BYTES));
   assign accept_o  = commit_i && !running && cnt_legal;
   assign last_unit = running && unit_end_i && (units_q == UW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CYC_IDLE;
         mode_q  <= WMODE_BYTE;
         addr_q  <= '0;
         base_q  <= '0;
         cnt_q   <= '0;
         units_q <= '0;
         slot_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_o) begin
            state_q <= CYC_RUN;
            mode_q  <= commit_page_i ? WMODE_PAGE : WMODE_BYTE;
            addr_q  <= commit_addr_i;
            base_q  <= commit_addr_i;
            cnt_q   <= commit_cnt_i;
            units_q <= commit_page_i ? UW'(PAGE_UNITS) : UW'(commit_cnt_i);
            slot_q  <= '0;
         end else if (running && unit_end_i) begin
            units_q <= units_q - 1'b1;
            if (mode_q == WMODE_BYTE) begin
               addr_q <= addr_q + 1'b1;
               slot_q <= slot_q + 1'b1;
            end
            if (last_unit) begin
               state_q <= CYC_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign busy_o      = running;
   assign done_o      = done_q;
   assign byte_we_o   = running && unit_end_i && (mode_q == WMODE_BYTE);
   assign byte_addr_o = addr_q;
   assign byte_slot_o = slot_q;
   assign flush_o     = last_unit && (mode_q == WMODE_PAGE);
   assign base_o      = base_q;
   assign cnt_o       = cnt_q;

endmodule

// File: rtl/ee_wcyc_store.sv
module ee_wcyc_store #(
   parameter  int unsigned ADDR_W     = 8,
   parameter  int unsigned DATA_W     = 8,
   parameter  int unsigned PAGE_BYTES = 8,
   localparam int unsigned DEPTH      = 1 << ADDR_W,
   localparam int unsigned PG_W       = $clog2(PAGE_BYTES),
   localparam int unsigned CW         = $clog2(PAGE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we_i,
   input  logic [PG_W-1:0]   stage_slot_i,
   input  logic [DATA_W-1:0] stage_data_i,
   input  logic              byte_we_i,
   input  logic [ADDR_W-1:0] byte_addr_i,
   input  logic [PG_W-1:0]   byte_slot_i,
   input  logic              flush_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] stage_q [PAGE_BYTES];
   logic [DATA_W-1:0] cell_q  [DEPTH];
   logic [DATA_W-1:0] wr_dat  [DEPTH];
   logic [DEPTH-1:0]  wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < PAGE_BYTES; s++) stage_q[s] <= '0;
      end else if (stage_we_i) begin
         stage_q[stage_slot_i] <= stage_data_i;
      end
   end

   // Per-word write decode: byte mode hits one word, a page flush hits
   // every word of the page whose offset from the start is below the count.
   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
         logic [PG_W-1:0] off;
         logic            in_page;
         logic            page_hit;

         assign off      = WA[PG_W-1:0] - base_i[PG_W-1:0];
         assign in_page  = (WA[ADDR_W-1:PG_W] == base_i[ADDR_W-1:PG_W]);
         assign page_hit = flush_i && in_page && (CW'(off) < cnt_i);
         assign wr_en[w] = page_hit || (byte_we_i && (byte_addr_i == WA));
         assign wr_dat[w] = flush_i ? stage_q[off] : stage_q[byte_slot_i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en[i]) cell_q[i] <= wr_dat[i];
         end
      end
   end

   assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/ee_wcyc_seq.sv
module ee_wcyc_seq #(
   parameter  int unsigned ADDR_W     = 8,
   parameter  int unsigned DATA_W     = 8,
   parameter  int unsigned PAGE_BYTES = 8,
   parameter  int unsigned PAGE_UNITS = 9,
   parameter  int unsigned UNIT_CLKS  = 7000,
   parameter  bit          EXT_TB_EN  = 1'b1,
   parameter  int unsigned EXT_MIN    = 4,
   parameter  int unsigned EXT_MAX    = 10,
   localparam int unsigned PG_W       = $clog2(PAGE_BYTES),
   localparam int unsigned CW         = $clog2(PAGE_BYTES + 1),
   localparam int unsigned LW         = $clog2(EXT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we_i,
   input  logic [PG_W-1:0]   stage_slot_i,
   input  logic [DATA_W-1:0] stage_data_i,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] commit_addr_i,
   input  logic [CW-1:0]     commit_cnt_i,
   input  logic              commit_page_i,
   input  logic              tb_ext_i,
   input  logic [LW-1:0]     ext_len_i,
   input  logic              ext_tick_i,
   input  logic              addr_hit_i,
   output logic              ack_o,
   output logic              busy_o,
   output logic              done_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (PAGE_BYTES >= (1 << ADDR_W)) begin : g_bad_depth
         $error("PAGE_BYTES must be smaller than the array");
      end
      if (UNIT_CLKS < 2 || PAGE_UNITS < 1) begin : g_bad_unit
         $error("UNIT_CLKS must be at least 2 and PAGE_UNITS at least 1");
      end
      if (EXT_MIN < 1 || EXT_MIN > EXT_MAX) begin : g_bad_ext
         $error("EXT_MIN must lie in 1..EXT_MAX");
      end
   endgenerate

   logic              accept;
   logic              unit_end;
   logic              busy;
   logic              byte_we;
   logic [ADDR_W-1:0] byte_addr;
   logic [PG_W-1:0]   byte_slot;
   logic              flush;
   logic [ADDR_W-1:0] base;
   logic [CW-1:0]     cnt;

   ee_wcyc_timebase #(
      .UNIT_CLKS (UNIT_CLKS),
      .EXT_TB_EN (EXT_TB_EN),
      .EXT_MIN   (EXT_MIN),
      .EXT_MAX   (EXT_MAX)
   ) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (accept),
      .run_i      (busy),
      .use_ext_i  (tb_ext_i),
      .ext_len_i  (ext_len_i),
      .ext_tick_i (ext_tick_i),
      .unit_end_o (unit_end)
   );

   ee_wcyc_ctrl #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .PAGE_UNITS (PAGE_UNITS)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit_i      (commit_i),
      .commit_addr_i (commit_addr_i),
      .commit_cnt_i  (commit_cnt_i),
      .commit_page_i (commit_page_i),
      .unit_end_i    (unit_end),
      .accept_o      (accept),
      .busy_o        (busy),
      .done_o        (done_o),
      .byte_we_o     (byte_we),
      .byte_addr_o   (byte_addr),
      .byte_slot_o   (byte_slot),
      .flush_o       (flush),
      .base_o        (base),
      .cnt_o         (cnt)
   );

   ee_wcyc_store #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .stage_we_i   (stage_we_i && !busy),
      .stage_slot_i (stage_slot_i),
      .stage_data_i (stage_data_i),
      .byte_we_i    (byte_we),
      .byte_addr_i  (byte_addr),
      .byte_slot_i  (byte_slot),
      .flush_i      (flush),
      .base_i       (base),
      .cnt_i        (cnt),
      .rd_addr_i    (rd_addr_i),
      .rd_data_o    (rd_data_o)
   );

   assign busy_o = busy;
   assign ack_o  = addr_hit_i && !busy;

endmodule

// File: rtl/ee_wcyc_chk.sv
module ee_wcyc_chk #(
   parameter  int unsigned PAGE_BYTES = 8,
   parameter  int unsigned PAGE_UNITS = 9,
   parameter  int unsigned UNIT_CLKS  = 7000,
   parameter  bit          EXT_TB_EN  = 1'b1,
   localparam int unsigned CW         = $clog2(PAGE_BYTES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          commit_i,
   input logic [CW-1:0] commit_cnt_i,
   input logic          commit_page_i,
   input logic          tb_ext_i,
   input logic          addr_hit_i,
   input logic          ack_o,
   input logic          busy_o,
   input logic          done_o
);

   logic        legal_go;
   logic        bad_go;
   logic [31:0] run_cnt;
   logic [31:0] exp_cnt;
   logic        ext_l;

   assign legal_go = !busy_o && commit_i && (commit_cnt_i != '0) &&
                     (commit_cnt_i <= CW'(PAGE_BYTES));
   assign bad_go   = !busy_o && commit_i && ((commit_cnt_i == '0) ||
                     (commit_cnt_i > CW'(PAGE_BYTES)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         exp_cnt <= '0;
         ext_l   <= 1'b0;
      end else if (legal_go) begin
         run_cnt <= '0;
         exp_cnt <= (commit_page_i ? 32'(PAGE_UNITS) : 32'(commit_cnt_i)) * 32'(UNIT_CLKS);
         ext_l   <= tb_ext_i && EXT_TB_EN;
      end else if (busy_o) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   a_r2_commit_starts: assert property (@(posedge clk) disable iff (!rst_n)
      legal_go |=> busy_o);

   a_r8_bad_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bad_go |=> !busy_o);

   a_r9_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ack_o);

   a_r9_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && addr_hit_i) |-> ack_o);

   // R3 and R4: cycle length on the internal timebase
   a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (ext_l || run_cnt == exp_cnt));

   a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r11_done_only_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind ee_wcyc_seq ee_wcyc_chk #(
   .PAGE_BYTES (PAGE_BYTES),
   .PAGE_UNITS (PAGE_UNITS),
   .UNIT_CLKS  (UNIT_CLKS),
   .EXT_TB_EN  (EXT_TB_EN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .commit_i      (commit_i),
   .commit_cnt_i  (commit_cnt_i),
   .commit_page_i (commit_page_i),
   .tb_ext_i      (tb_ext_i),
   .addr_hit_i    (addr_hit_i),
   .ack_o         (ack_o),
   .busy_o        (busy_o),
   .done_o        (done_o)
);

// File: tb/ee_wcyc_seq_test.sv
module ee_wcyc_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int U          = 12;
   localparam int PU         = 9;

   logic       clk;
   logic       rst_n;
   logic       stage_we_i;
   logic [2:0] stage_slot_i;
   logic [7:0] stage_data_i;
   logic       commit_i;
   logic [7:0] commit_addr_i;
   logic [3:0] commit_cnt_i;
   logic       commit_page_i;
   logic       tb_ext_i;
   logic [3:0] ext_len_i;
   logic       ext_tick_i;
   logic       addr_hit_i;
   logic       ack_o;
   logic       busy_o;
   logic       done_o;
   logic [7:0] rd_addr_i;
   logic [7:0] rd_data_o;

   int         n_chk;
   int         n_fail;
   int         cyc;
   logic [7:0] mdl [256];
   logic [7:0] stg [8];

   ee_wcyc_seq #(.UNIT_CLKS(U)) uut (
      .clk(clk), .rst_n(rst_n),
      .stage_we_i(stage_we_i), .stage_slot_i(stage_slot_i), .stage_data_i(stage_data_i),
      .commit_i(commit_i), .commit_addr_i(commit_addr_i), .commit_cnt_i(commit_cnt_i),
      .commit_page_i(commit_page_i), .tb_ext_i(tb_ext_i), .ext_len_i(ext_len_i),
      .ext_tick_i(ext_tick_i), .addr_hit_i(addr_hit_i), .ack_o(ack_o),
      .busy_o(busy_o), .done_o(done_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a);
      rd_addr_i = a;
      #1;
      check(req, rd_data_o, mdl[a]);
   endtask

   task automatic load_stage(input int slot, input logic [7:0] d);
      @(negedge clk);
      stage_we_i = 1'b1; stage_slot_i = 3'(slot); stage_data_i = d;
      if (!busy_o) stg[slot] = d;
      @(negedge clk);
      stage_we_i = 1'b0;
   endtask

   function automatic int clamp_len(input int l);
      return (l < 4) ? 4 : ((l > 10) ? 10 : l);
   endfunction

   task automatic model_write(input logic [7:0] a, input int c, input bit pg);
      for (int k = 0; k < c; k++) begin
         if (pg) mdl[{a[7:3], 3'(a[2:0] + 3'(k))}] = stg[k];
         else    mdl[8'(a + 8'(k))] = stg[k];
      end
   endtask

   // Commit, then run until busy drops; returns busy cycles and ticks given.
   task automatic run_cycle(input logic [7:0] a, input int c, input bit pg,
                            input bit ext, input int len, input logic [7:0] paddr,
                            input int pn, output int ncyc, output int nticks,
                            output logic [7:0] vb, output logic [7:0] va);
      ncyc = 0; nticks = 0; vb = 8'h00; va = 8'h00;
      @(negedge clk);
      commit_i = 1'b1; commit_addr_i = a; commit_cnt_i = 4'(c);
      commit_page_i = pg; tb_ext_i = ext; ext_len_i = 4'(len); rd_addr_i = paddr;
      @(negedge clk);
      commit_i = 1'b0;
      check("R2 busy after commit", busy_o, 1);
      while (busy_o) begin
         ncyc++;
         if (ncyc == pn)     vb = rd_data_o;
         if (ncyc == pn + 1) va = rd_data_o;
         if (ext) begin
            ext_tick_i = (ncyc % 3 == 1);
            if (ext_tick_i) nticks++;
         end
         @(negedge clk);
      end
      ext_tick_i = 1'b0;
      check("R11 done after fall", done_o, 1);
      @(negedge clk);
      check("R11 done single cycle", done_o, 0);
      model_write(a, c, pg);
   endtask

   task automatic t_reset();
      check("R1 busy at reset", busy_o, 0);
      check("R1 done at reset", done_o, 0);
      rd_chk("R1 erased word 00", 8'h00);
      rd_chk("R1 erased word FF", 8'hFF);
   endtask

   task automatic t_byte_write();
      int nc, nt;
      logic [7:0] vb, va;
      for (int k = 0; k < 8; k++) load_stage(k, 8'hA0 + 8'(k));
      run_cycle(8'h10, 3, 1'b0, 1'b0, 0, 8'h10, U, nc, nt, vb, va);
      check("R3 byte busy length", nc, 3 * U);
      check("R7 byte0 not yet written", vb, 8'hFF);
      check("R7 byte0 written after first unit", va, 8'hA0);
      rd_chk("R5 byte addr 10", 8'h10);
      rd_chk("R5 byte addr 12", 8'h12);
      rd_chk("R5 byte addr 13 untouched", 8'h13);
   endtask

   task automatic t_byte_wrap();
      int nc, nt;
      logic [7:0] vb, va;
      run_cycle(8'hFE, 4, 1'b0, 1'b0, 0, 8'h00, 0, nc, nt, vb, va);
      check("R3 byte busy length 4", nc, 4 * U);
      rd_chk("R5 wrap FE", 8'hFE);
      rd_chk("R5 wrap FF", 8'hFF);
      rd_chk("R5 wrap 00", 8'h00);
      rd_chk("R5 wrap 01", 8'h01);
   endtask

   task automatic t_page_write();
      int nc, nt;
      logic [7:0] vb, va;
      for (int k = 0; k < 8; k++) load_stage(k, 8'h30 + 8'(k));
      run_cycle(8'h45, 5, 1'b1, 1'b0, 0, 8'h45, PU * U, nc, nt, vb, va);
      check("R4 page busy length cnt5", nc, PU * U);
      check("R7 page not written before last unit", vb, 8'hFF);
      rd_chk("R6 page 45", 8'h45);
      rd_chk("R6 page 47", 8'h47);
      rd_chk("R6 page wrap 40", 8'h40);
      rd_chk("R6 page wrap 41", 8'h41);
      rd_chk("R6 page 42 untouched", 8'h42);
      rd_chk("R6 next page 48 untouched", 8'h48);
      run_cycle(8'h20, 8, 1'b1, 1'b0, 0, 8'h20, 0, nc, nt, vb, va);
      check("R4 page busy length cnt8", nc, PU * U);
      rd_chk("R6 full page 20", 8'h20);
      rd_chk("R6 full page 27", 8'h27);
   endtask

   task automatic t_bad_commit();
      for (int c = 0; c <= 9; c += 9) begin
         @(negedge clk);
         commit_i = 1'b1; commit_addr_i = 8'h60; commit_cnt_i = 4'(c); commit_page_i = 1'b0;
         @(negedge clk);
         commit_i = 1'b0;
         check("R8 illegal count no start", busy_o, 0);
         @(negedge clk);
         check("R8 illegal count still idle", busy_o, 0);
      end
      rd_chk("R8 illegal count no write", 8'h60);
   endtask

   task automatic t_busy_block();
      int nc;
      logic [7:0] keep;
      load_stage(0, 8'h11);
      keep = stg[0];
      @(negedge clk);
      commit_i = 1'b1; commit_addr_i = 8'h80; commit_cnt_i = 4'd1;
      commit_page_i = 1'b0; tb_ext_i = 1'b0;
      @(negedge clk);
      commit_i = 1'b0; nc = 1;
      addr_hit_i = 1'b1;
      #1;
      check("R9 ack blocked while busy", ack_o, 0);
      @(negedge clk); nc++;
      commit_i = 1'b1; commit_addr_i = 8'h90; commit_cnt_i = 4'd2;
      stage_we_i = 1'b1; stage_slot_i = 3'd0; stage_data_i = 8'h5A;
      @(negedge clk); nc++;
      commit_i = 1'b0; stage_we_i = 1'b0;
      while (busy_o) begin
         @(negedge clk);
         if (busy_o) nc++;
      end
      check("R8 commit while busy does not extend", nc, U);
      check("R9 ack follows hit when idle", ack_o, 1);
      addr_hit_i = 1'b0;
      mdl[8'h80] = keep;
      rd_chk("R8 busy commit no write 90", 8'h90);
      rd_chk("R5 single byte 80", 8'h80);
      @(negedge clk);
      commit_i = 1'b1; commit_addr_i = 8'h81; commit_cnt_i = 4'd1;
      @(negedge clk);
      commit_i = 1'b0;
      while (busy_o) @(negedge clk);
      mdl[8'h81] = keep;
      rd_chk("R9 staging write during busy dropped", 8'h81);
   endtask

   task automatic t_ext_tb();
      int nc, nt;
      logic [7:0] vb, va;
      run_cycle(8'hB0, 2, 1'b0, 1'b1, 5, 8'h00, 0, nc, nt, vb, va);
      check("R10 ext ticks len5 cnt2", nt, 2 * 5);
      rd_chk("R10 ext byte B1", 8'hB1);
      run_cycle(8'hC3, 1, 1'b1, 1'b1, 2, 8'h00, 0, nc, nt, vb, va);
      check("R10 ext clamp low page", nt, PU * clamp_len(2));
      rd_chk("R10 ext page C3", 8'hC3);
      run_cycle(8'hD0, 1, 1'b0, 1'b1, 15, 8'h00, 0, nc, nt, vb, va);
      check("R10 ext clamp high", nt, clamp_len(15));
   endtask

   initial begin
      n_chk = 0; n_fail = 0; cyc = 0;
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      for (int i = 0; i < 8; i++) stg[i] = 8'h00;
      rst_n = 1'b0; stage_we_i = 1'b0; stage_slot_i = '0; stage_data_i = '0;
      commit_i = 1'b0; commit_addr_i = '0; commit_cnt_i = '0; commit_page_i = 1'b0;
      tb_ext_i = 1'b0; ext_len_i = '0; ext_tick_i = 1'b0; addr_hit_i = 1'b0; rd_addr_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_write();
      t_byte_wrap();
      t_page_write();
      t_bad_commit();
      t_busy_block();
      t_ext_tb();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule